// File: doc/BRIEF.md
# Three-Wire Serial Control Register Receiver

This block receives configuration bytes from a host over three slow wires (a mode line, a serial clock and a serial data line) and holds the resulting control fields for an audio converter. The wires are sampled by the system clock. A byte sent while the mode line is low is an address byte. It either selects this device and one of its register banks, or it deselects the device. Bytes sent while the mode line is high are data bytes. Each one is steered by its two top bits to one register group within the selected bank.

The decoded fields drive the converter's clocking, serial format, DC filter, volume, tone, de-emphasis, mute, tone-filter mode and power enables. Volume is also given as an attenuation in whole dB. Bass and treble are given as a boost in dB that depends on the filter mode. Data flows one way only, and there is no readback.

Top module: `ctl3w_rx`

## Requirements
- R1: Each byte is eight serial-clock rising edges with the least significant bit first. A byte has effect only after its eighth bit, and its fields appear at the outputs within eight system clock cycles of that edge.
- R2: A byte sent with the mode line low is an address. Bits 7..2 equal to 000101 select the device, and bits 1..0 choose the bank: 00 is the sound bank, 10 is the status bank, and 01 or 11 select a bank whose data bytes change nothing.
- R3: An address whose bits 7..2 differ from 000101 deselects the device, so that later data bytes change nothing. A valid selection stays in force for any number of data bytes until the next address byte.
- R4: In the status bank, a byte with bits 7..6 = 00 loads the clock rate from bits 5..4 (00 = 512, 01 = 384, 10 = 256 times the sample rate), the serial format from bits 3..1 and the DC filter enable from bit 0. Any other prefix is ignored.
- R5: In the sound bank, prefix 00 (bits 7..6) loads the 6-bit volume code from bits 5..0.
- R6: In the sound bank, prefix 01 loads the bass code from bits 5..2 and the treble code from bits 1..0.
- R7: In the sound bank, prefix 10 loads de-emphasis from bits 4..3, mute from bit 2 and the filter mode from bits 1..0. Bit 5 is ignored.
- R8: In the sound bank, prefix 11 with bits 5..2 all zero loads the ADC enable from bit 1 and the DAC enable from bit 0. With any of bits 5..2 set, the byte is ignored.
- R9: The volume attenuation output is 0 for codes 0 and 1 and (code - 1) dB for codes 2 to 61. It is 127 (full attenuation) for codes 62 and 63.
- R10: Bass boost is 0 dB in filter mode 00. In modes 01 and 10 it is 2 dB per code, capped at 18 dB. In mode 11 it is 2 dB per code, capped at 24 dB. Treble is 0 dB in mode 00 and 2 dB per code otherwise.
- R11: Any change of the mode line discards the bits of an unfinished byte, so the next byte is framed from its own first bit.
- R12: After reset all outputs are zero and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode_i | input | 1 | Mode line: low for an address byte, high for data bytes |
| ser_clk_i | input | 1 | Serial bit clock from the host |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| clk_rate_o | output | 2 | System clock rate code |
| fmt_o | output | 3 | Serial audio format code |
| dc_en_o | output | 1 | DC filter enable |
| vol_code_o | output | 6 | Raw volume code |
| vol_atten_db_o | output | 7 | Volume attenuation in dB, 127 for full attenuation |
| bass_code_o | output | 4 | Raw bass code |
| treble_code_o | output | 2 | Raw treble code |
| bass_db_o | output | 5 | Effective bass boost in dB |
| treble_db_o | output | 3 | Effective treble boost in dB |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Mute |
| fmode_o | output | 2 | Tone filter mode |
| adc_on_o | output | 1 | ADC power enable |
| dac_on_o | output | 1 | DAC power enable |

## Verification
The bench aims at the bank and prefix corners. If a design decoded prefix 11 without checking bits 5..2, a stray byte would switch the power enables. A reserved-bank or foreign address that left the device selected would let later bytes corrupt the volume. The bench also checks the volume codes 0, 1, 2, 61, 62 and 63 and the points where bass saturates in each filter mode; an off-by-one there shows up as a wrong dB value. Finally, it abandons a byte after five bits and follows it with a new address. A receiver that kept its bit count across the mode change would misframe that address and miss the following status write.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  localparam int BYTE_BITS = 8;
  localparam logic [6:0] ATTEN_FULL = 7'd127;

  typedef enum logic [1:0] {
    BANK_SOUND = 2'b00,
    BANK_RSV_A = 2'b01,
    BANK_STAT  = 2'b10,
    BANK_RSV_B = 2'b11
  } bank_e;

  typedef enum logic [1:0] {
    GRP_VOL  = 2'b00,
    GRP_TONE = 2'b01,
    GRP_MISC = 2'b10,
    GRP_PWR  = 2'b11
  } grp_e;

  // Volume code to attenuation in dB.
  function automatic logic [6:0] f_vol_atten(input logic [5:0] code);
    logic [6:0] r;
    if (code >= 6'd62)      r = ATTEN_FULL;
    else if (code == 6'd0)  r = 7'd0;
    else                    r = {1'b0, code} - 7'd1;
    return r;
  endfunction

  // Bass code to boost in dB, depending on the tone filter mode.
  function automatic logic [4:0] f_bass_db(input logic [3:0] code, input logic [1:0] fm);
    logic [4:0] raw;
    logic [4:0] r;
    raw = {code, 1'b0};
    case (fm)
      2'b00:   r = 5'd0;
      2'b11:   r = (raw > 5'd24) ? 5'd24 : raw;
      default: r = (raw > 5'd18) ? 5'd18 : raw;
    endcase
    return r;
  endfunction

  // Treble code to boost in dB.
  function automatic logic [2:0] f_treble_db(input logic [1:0] code, input logic [1:0] fm);
    return (fm == 2'b00) ? 3'd0 : {code, 1'b0};
  endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smode,
  input  logic                 sclk,
  input  logic                 sdat,
  output logic                 rise_o,
  output logic                 mode_edge_o,
  output logic                 byte_stb_o,
  output logic                 byte_addr_o,
  output logic [BYTE_BITS-1:0] byte_o
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic             sclk_d, mode_d;
  logic [CNT_W-1:0] bit_cnt;

  assign rise_o      = sclk & ~sclk_d;
  assign mode_edge_o = smode ^ mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d      <= 1'b0;
      mode_d      <= 1'b0;
      bit_cnt     <= '0;
      byte_o      <= '0;
      byte_stb_o  <= 1'b0;
      byte_addr_o <= 1'b0;
    end else begin
      sclk_d     <= sclk;
      mode_d     <= smode;
      byte_stb_o <= 1'b0;
      if (mode_edge_o) begin
        bit_cnt <= '0;
      end else if (rise_o) begin
        byte_o  <= {sdat, byte_o[BYTE_BITS-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_stb_o  <= 1'b1;
          byte_addr_o <= ~smode;
        end
      end
    end
  end

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_stb,
  input  logic                 byte_addr,
  input  logic [BYTE_BITS-1:0] byte_val,
  output logic                 dev_sel_o,
  output logic                 wr_sound_o,
  output logic                 wr_stat_o,
  output logic [1:0]           clk_rate_o,
  output logic [2:0]           fmt_o,
  output logic                 dc_en_o,
  output logic [5:0]           vol_o,
  output logic [3:0]           bass_o,
  output logic [1:0]           treble_o,
  output logic [1:0]           deemph_o,
  output logic                 mute_o,
  output logic [1:0]           fmode_o,
  output logic                 adc_on_o,
  output logic                 dac_on_o
);

  bank_e bank_q;
  grp_e  grp;

  assign grp        = grp_e'(byte_val[7:6]);
  assign wr_sound_o = byte_stb && !byte_addr && dev_sel_o && (bank_q == BANK_SOUND);
  assign wr_stat_o  = byte_stb && !byte_addr && dev_sel_o && (bank_q == BANK_STAT)
                      && (byte_val[7:6] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sel_o <= 1'b0;
      bank_q    <= BANK_SOUND;
    end else if (byte_stb && byte_addr) begin
      dev_sel_o <= (byte_val[7:2] == DEV_ADDR);
      bank_q    <= bank_e'(byte_val[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_rate_o <= '0;
      fmt_o      <= '0;
      dc_en_o    <= 1'b0;
    end else if (wr_stat_o) begin
      clk_rate_o <= byte_val[5:4];
      fmt_o      <= byte_val[3:1];
      dc_en_o    <= byte_val[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_o    <= '0;
      bass_o   <= '0;
      treble_o <= '0;
      deemph_o <= '0;
      mute_o   <= 1'b0;
      fmode_o  <= '0;
      adc_on_o <= 1'b0;
      dac_on_o <= 1'b0;
    end else if (wr_sound_o) begin
      case (grp)
        GRP_VOL:  vol_o <= byte_val[5:0];
        GRP_TONE: begin
          bass_o   <= byte_val[5:2];
          treble_o <= byte_val[1:0];
        end
        GRP_MISC: begin
          deemph_o <= byte_val[4:3];
          mute_o   <= byte_val[2];
          fmode_o  <= byte_val[1:0];
        end
        GRP_PWR: begin
          if (byte_val[5:2] == 4'b0000) begin
            adc_on_o <= byte_val[1];
            dac_on_o <= byte_val[0];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'b000101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_mode_i,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  output logic [1:0] clk_rate_o,
  output logic [2:0] fmt_o,
  output logic       dc_en_o,
  output logic [5:0] vol_code_o,
  output logic [6:0] vol_atten_db_o,
  output logic [3:0] bass_code_o,
  output logic [1:0] treble_code_o,
  output logic [4:0] bass_db_o,
  output logic [2:0] treble_db_o,
  output logic [1:0] deemph_o,
  output logic       mute_o,
  output logic [1:0] fmode_o,
  output logic       adc_on_o,
  output logic       dac_on_o
);

  logic [2:0]           sync_q;
  logic                 rise_w, mode_edge_w, byte_stb_w, byte_addr_w;
  logic [BYTE_BITS-1:0] byte_w;
  logic                 dev_sel_w, wr_sound_w, wr_stat_w;

  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_mode_i, ser_clk_i, ser_dat_i}),
    .q     (sync_q)
  );

  ctl3w_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .smode       (sync_q[2]),
    .sclk        (sync_q[1]),
    .sdat        (sync_q[0]),
    .rise_o      (rise_w),
    .mode_edge_o (mode_edge_w),
    .byte_stb_o  (byte_stb_w),
    .byte_addr_o (byte_addr_w),
    .byte_o      (byte_w)
  );

  ctl3w_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb   (byte_stb_w),
    .byte_addr  (byte_addr_w),
    .byte_val   (byte_w),
    .dev_sel_o  (dev_sel_w),
    .wr_sound_o (wr_sound_w),
    .wr_stat_o  (wr_stat_w),
    .clk_rate_o (clk_rate_o),
    .fmt_o      (fmt_o),
    .dc_en_o    (dc_en_o),
    .vol_o      (vol_code_o),
    .bass_o     (bass_code_o),
    .treble_o   (treble_code_o),
    .deemph_o   (deemph_o),
    .mute_o     (mute_o),
    .fmode_o    (fmode_o),
    .adc_on_o   (adc_on_o),
    .dac_on_o   (dac_on_o)
  );

  assign vol_atten_db_o = f_vol_atten(vol_code_o);
  assign bass_db_o      = f_bass_db(bass_code_o, fmode_o);
  assign treble_db_o    = f_treble_db(treble_code_o, fmode_o);

endmodule

// File: rtl/ctl3w_rx_chk.sv
module ctl3w_rx_chk #(
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rise,
  input logic       mode_edge,
  input logic       byte_stb,
  input logic       byte_addr,
  input logic [7:0] byte_val,
  input logic       dev_sel,
  input logic       wr_sound,
  input logic       wr_stat,
  input logic [5:0] vol_code,
  input logic [6:0] atten,
  input logic [4:0] bass_db,
  input logic [1:0] fmode,
  input logic [1:0] clk_rate,
  input logic       adc_on,
  input logic       dac_on
);

  // R1: a byte completes only on a detected serial clock rise
  assert_stb_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(rise));

  // R1: completion strobe lasts a single cycle
  assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);

  // R3: a foreign address leaves the device deselected
  assert_foreign_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_addr && (byte_val[7:2] != DEV_ADDR)) |=> !dev_sel);

  // R3: no register write while deselected
  assert_no_write_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_sel |-> !(wr_sound || wr_stat));

  // R5: volume moves only after a completed data byte
  assert_vol_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_code) |-> $past(byte_stb && !byte_addr));

  // R4: clock rate moves only after a status write
  assert_rate_on_stat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_rate) |-> $past(wr_stat));

  // R8: power enables move only after a sound-bank write
  assert_pwr_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({adc_on, dac_on}) |-> $past(wr_sound));

  // R9: attenuation stays in its legal set
  assert_atten_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (atten <= 7'd60) || (atten == 7'd127));

  // R10: flat mode gives no bass boost
  assert_flat_bass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmode == 2'b00) |-> (bass_db == 5'd0));

  // R10: bass saturation per mode
  assert_bass_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bass_db <= 5'd24) && ((fmode == 2'b11) || (bass_db <= 5'd18)));

  // R11: a mode change never completes a byte
  assert_mode_edge_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_edge |=> !byte_stb);

endmodule

bind ctl3w_rx ctl3w_rx_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise      (rise_w),
  .mode_edge (mode_edge_w),
  .byte_stb  (byte_stb_w),
  .byte_addr (byte_addr_w),
  .byte_val  (byte_w),
  .dev_sel   (dev_sel_w),
  .wr_sound  (wr_sound_w),
  .wr_stat   (wr_stat_w),
  .vol_code  (vol_code_o),
  .atten     (vol_atten_db_o),
  .bass_db   (bass_db_o),
  .fmode     (fmode_o),
  .clk_rate  (clk_rate_o),
  .adc_on    (adc_on_o),
  .dac_on    (dac_on_o)
);

// File: tb/ctl3w_rx_tb.sv
module ctl3w_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;

  logic [1:0] clk_rate; logic [2:0] fmt; logic dc_en;
  logic [5:0] vol; logic [6:0] atten; logic [3:0] bass; logic [1:0] treb;
  logic [4:0] bass_db; logic [2:0] treb_db; logic [1:0] de; logic mute;
  logic [1:0] fm; logic adc_on, dac_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl3w_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(ser_mode), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .clk_rate_o(clk_rate), .fmt_o(fmt), .dc_en_o(dc_en), .vol_code_o(vol),
    .vol_atten_db_o(atten), .bass_code_o(bass), .treble_code_o(treb),
    .bass_db_o(bass_db), .treble_db_o(treb_db), .deemph_o(de), .mute_o(mute),
    .fmode_o(fm), .adc_on_o(adc_on), .dac_on_o(dac_on)
  );

  wire [39:0] act = {clk_rate, fmt, dc_en, vol, atten, bass, treb, bass_db, treb_db,
                     de, mute, fm, adc_on, dac_on};

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  string       tag_q[$];
  logic [39:0] exp_q[$];

  // expectation model
  bit m_sel = 0; logic [1:0] m_bank = 0;
  logic [1:0] m_rate = 0; logic [2:0] m_fmt = 0; logic m_dc = 0;
  logic [5:0] m_vol = 0; logic [3:0] m_bass = 0; logic [1:0] m_treb = 0;
  logic [1:0] m_de = 0; logic m_mute = 0; logic [1:0] m_fm = 0;
  logic m_adc = 0, m_dac = 0;

  function automatic logic [6:0] exp_atten(input logic [5:0] c);
    int v;
    if (c > 6'd61) return 7'd127;
    v = int'(c) - 1;
    if (v < 0) v = 0;
    return 7'(v);
  endfunction

  function automatic logic [4:0] exp_bass(input logic [3:0] b, input logic [1:0] f);
    int cap;
    int v;
    if (f == 2'b00) return 5'd0;
    cap = (f == 2'b11) ? 24 : 18;
    v = 2 * int'(b);
    return 5'((v < cap) ? v : cap);
  endfunction

  function automatic logic [39:0] model_vec();
    logic [2:0] tdb;
    tdb = (m_fm == 2'b00) ? 3'd0 : 3'(2 * int'(m_treb));
    return {m_rate, m_fmt, m_dc, m_vol, exp_atten(m_vol), m_bass, m_treb,
            exp_bass(m_bass, m_fm), tdb, m_de, m_mute, m_fm, m_adc, m_dac};
  endfunction

  task automatic model_byte(input bit is_addr, input logic [7:0] b);
    if (is_addr) begin
      m_sel  = (b[7:2] == 6'b000101);
      m_bank = b[1:0];
    end else if (m_sel) begin
      if (m_bank == 2'b10) begin
        if (b[7:6] == 2'b00) begin m_rate = b[5:4]; m_fmt = b[3:1]; m_dc = b[0]; end
      end else if (m_bank == 2'b00) begin
        case (b[7:6])
          2'b00: m_vol = b[5:0];
          2'b01: begin m_bass = b[5:2]; m_treb = b[1:0]; end
          2'b10: begin m_de = b[4:3]; m_mute = b[2]; m_fm = b[1:0]; end
          default: if (b[5:2] == 4'd0) begin m_adc = b[1]; m_dac = b[0]; end
        endcase
      end
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input bit mode_hi, input logic [7:0] b, input int nbits);
    ser_mode = mode_hi;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = b[i];
      wait_clk(HALF_BIT);
      ser_clk = 1'b1;
      wait_clk(HALF_BIT);
      ser_clk = 1'b0;
    end
    wait_clk(10);
  endtask

  task automatic push(input string tag);
    tag_q.push_back(tag);
    exp_q.push_back(model_vec());
    wait_clk(2);
  endtask

  task automatic xfer(input bit is_addr, input logic [7:0] b, input string tag);
    send_bits(!is_addr, b, 8);
    model_byte(is_addr, b);
    push(tag);
  endtask

  // monitor: pops expectations and compares the outputs
  initial begin
    forever begin
      string t;
      logic [39:0] e;
      wait (exp_q.size() > 0);
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      n_checks++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    push("R12 reset state");

    // R2 R1 R5 select sound bank, LSB-first volume
    xfer(1, 8'h14, "R2 select sound bank");
    xfer(0, 8'h2A, "R1 R5 volume 42");
    // R9 boundaries
    xfer(0, 8'h00, "R9 vol 0");
    xfer(0, 8'h01, "R9 vol 1");
    xfer(0, 8'h02, "R9 vol 2");
    xfer(0, 8'h3D, "R9 vol 61");
    xfer(0, 8'h3E, "R9 vol 62");
    xfer(0, 8'h3F, "R9 vol 63");
    // R6 tone with flat mode, then R7 and R10 across modes
    xfer(0, 8'h73, "R6 bass 12 treble 3 flat");
    xfer(0, 8'h95, "R7 R10 deemph 2 mute min mode");
    xfer(0, 8'h97, "R10 max mode bass 12");
    xfer(0, 8'h7C, "R10 max mode bass 15");
    xfer(0, 8'h96, "R10 min mode 10 bass 15");
    xfer(0, 8'h52, "R10 bass 4 treble 2");
    xfer(0, 8'hA9, "R7 bit5 ignored");
    // R8 power
    xfer(0, 8'hC2, "R8 adc on dac off");
    xfer(0, 8'hC3, "R8 both on");
    xfer(0, 8'hC4, "R8 nonzero filler ignored");
    xfer(0, 8'hE0, "R8 nonzero filler ignored 2");
    // R4 status bank
    xfer(1, 8'h16, "R2 select status bank");
    xfer(0, 8'h2B, "R4 rate 256 fmt 5 dc on");
    xfer(0, 8'h6B, "R4 prefix ignored");
    xfer(0, 8'h05, "R2 status bank leaves volume");
    xfer(0, 8'h1C, "R4 rate 384 fmt 6 dc off");
    // R2 reserved bank
    xfer(1, 8'h15, "R2 reserved bank");
    xfer(0, 8'h05, "R2 reserved bank ignores volume");
    // R3 foreign address then reselect with multiple bytes
    xfer(1, 8'h24, "R3 foreign address");
    xfer(0, 8'h05, "R3 deselected ignores volume");
    xfer(0, 8'hC0, "R3 deselected ignores power");
    xfer(1, 8'h14, "R3 reselect");
    xfer(0, 8'h03, "R3 persist byte 1");
    xfer(0, 8'h45, "R3 persist byte 2");
    xfer(0, 8'h80, "R3 persist byte 3");
    // R11 partial byte then new address
    send_bits(1, 8'hFF, 5);
    xfer(1, 8'h16, "R11 address after partial");
    xfer(0, 8'h01, "R11 status after partial");
    send_bits(0, 8'h0F, 3);
    xfer(0, 8'h3F, "R11 data after partial address");

    wait (exp_q.size() == 0);
    wait_clk(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule